// File: doc/BRIEF.md
# Per-Port Cell Arrival Timeout Monitor

This block watches cell traffic on a set of receive ports and raises an alarm when a port goes quiet for too long. Each port has its own elapsed-time counter. A shared 125 µs tick strobe advances every counter at once, and any cell arrival on a port sends that port's counter back to zero. Each counter is compared against two limits. The first is a late-cell period held in the port's own configuration word. The second is a cut-circuit period shared by all ports. Crossing either limit sets a sticky status bit for that port.

A late event is honoured only while the port runs in unstructured-transport mode. When the global late-check control is also on, the event emits a one-cycle request to insert a filler cell into that port's reassembly buffer. Each status bit has its own service enable. An enabled status bit raises the port's bit in a timeout summary vector, and any raised summary bit raises a global service flag.

Software reads and writes one 16-bit word per port through a simple register port. The word holds the late period, both service enables and both status bits. Status bits are cleared by writing 0 to them.

Top module: `cell_timeout_monitor`

## Requirements
- R1: After reset every port word reads 0x07FF, and `timeout_vec`, `rx_timeout_srv` and `dummy_req` are all 0.
- R2: A port's elapsed counter goes to 0 on a cell arrival and otherwise advances by one on each tick. If an arrival and a tick come in the same cycle, the arrival wins. The counter stops at 2047 and never wraps, so a silence that has already fired does not fire again.
- R3: The late status bit (bit 12) is set once the elapsed count is at least the late period (bits 10:0), but only while `udt_mode[p]` is 1. It fires at most once per silence interval and is re-armed only by a new arrival.
- R4: The cut status bit (bit 14) is set once the elapsed count is at least `cut_period`, whatever the port's mode. It fires at most once per silence interval and is re-armed only by a new arrival.
- R5: `dummy_req[p]` pulses high for exactly one cycle when a late event fires on port p while `check_late` is 1. It stays low at all other times.
- R6: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: `timeout_vec[p]` = (bit 12 AND bit 11) OR (bit 14 AND bit 13) of port p's word, and `rx_timeout_srv` is the OR of all `timeout_vec` bits.
- R8: A write with `reg_addr` = p loads bits 10:0 (late period), bit 11 (late service enable) and bit 13 (cut service enable) of port p's word. `reg_rdata` shows port p's word combinationally, and bit 15 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_arrival | input | NUM_PORTS | One-cycle pulse per port when a cell arrives |
| tick_125us | input | 1 | One-cycle time-base strobe shared by all ports |
| udt_mode | input | NUM_PORTS | Port runs in unstructured mode (enables late events) |
| check_late | input | 1 | Global enable for filler-cell requests |
| cut_period | input | CUT_W | Shared cut-circuit limit in ticks |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Port index of the register access |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Addressed port word |
| timeout_vec | output | NUM_PORTS | Per-port enabled-timeout summary |
| rx_timeout_srv | output | 1 | Global receive-timeout service flag |
| dummy_req | output | NUM_PORTS | One-cycle request to insert a filler cell |

## Verification
The assertions check on every cycle that an arrival clears the counter, that a saturated counter holds, that each event cannot fire twice in a row, that status bits stay set unless a write clears them, that a set always lands, and that filler requests are single pulses following the late-check control. Only the bench's scenarios can show the exact tick count at which each threshold trips, the gating of late events by mode, the service-enable combinations behind the summary vector, and the absence of any repeat after the counter saturates during a long silence.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int PERIOD_W    = 11;
    localparam int WORD_W      = 16;
    localparam int LATE_SE_BIT = 11;
    localparam int LATE_ST_BIT = 12;
    localparam int CUT_SE_BIT  = 13;
    localparam int CUT_ST_BIT  = 14;

    localparam logic [WORD_W-1:0] WORD_RESET = 16'h07FF;

    typedef struct packed {
        logic                cut_se;
        logic                late_se;
        logic [PERIOD_W-1:0] late_period;
    } port_cfg_t;

    typedef struct packed {
        logic cut;
        logic late;
    } flag_pair_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(port_cfg_t c, flag_pair_t s);
        logic [WORD_W-1:0] w;
        w                 = '0;
        w[PERIOD_W-1:0]   = c.late_period;
        w[LATE_SE_BIT]    = c.late_se;
        w[LATE_ST_BIT]    = s.late;
        w[CUT_SE_BIT]     = c.cut_se;
        w[CUT_ST_BIT]     = s.cut;
        return w;
    endfunction

    function automatic port_cfg_t unpack_cfg(logic [WORD_W-1:0] w);
        port_cfg_t c;
        c.late_period = w[PERIOD_W-1:0];
        c.late_se     = w[LATE_SE_BIT];
        c.cut_se      = w[CUT_SE_BIT];
        return c;
    endfunction

    function automatic flag_pair_t clear_request(logic [WORD_W-1:0] w);
        flag_pair_t m;
        m.late = ~w[LATE_ST_BIT];
        m.cut  = ~w[CUT_ST_BIT];
        return m;
    endfunction

endpackage

// File: rtl/ctm_port_timer.sv
module ctm_port_timer
    import ctm_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int CUT_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arrival,
    input  logic                tick,
    input  logic                udt_mode,
    input  logic [PERIOD_W-1:0] late_period,
    input  logic [CUT_W-1:0]    cut_period,
    output flag_pair_t          evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] elapsed;
    logic             late_armed;
    logic             cut_armed;

    always_comb begin
        evt.late = late_armed & ~arrival & udt_mode &
                   (elapsed >= CNT_W'(late_period));
        evt.cut  = cut_armed & ~arrival &
                   (elapsed >= CNT_W'(cut_period));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed    <= '0;
            late_armed <= 1'b1;
            cut_armed  <= 1'b1;
        end else if (arrival) begin
            elapsed    <= '0;
            late_armed <= 1'b1;
            cut_armed  <= 1'b1;
        end else begin
            if (tick && elapsed != CNT_MAX)
                elapsed <= elapsed + CNT_W'(1);
            if (evt.late)
                late_armed <= 1'b0;
            if (evt.cut)
                cut_armed <= 1'b0;
        end
    end

    AST_ARRIVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        arrival |=> elapsed == '0); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (elapsed == CNT_MAX && !arrival) |=> elapsed == CNT_MAX); // R2
    AST_LATE_ONCE: assert property (@(posedge clk) disable iff (rst)
        evt.late |=> !evt.late); // R3
    AST_CUT_ONCE: assert property (@(posedge clk) disable iff (rst)
        evt.cut |=> !evt.cut); // R4

endmodule

// File: rtl/ctm_port_csr.sv
module ctm_port_csr
    import ctm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  flag_pair_t        evt,
    output port_cfg_t         cfg,
    output logic [WORD_W-1:0] word,
    output logic              svc
);

    flag_pair_t status;
    flag_pair_t clr;

    always_comb begin
        clr      = clear_request(wdata);
        clr.late = clr.late & wr;
        clr.cut  = clr.cut & wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= unpack_cfg(WORD_RESET);
            status <= '0;
        end else begin
            if (wr)
                cfg <= unpack_cfg(wdata);
            status.late <= evt.late | (status.late & ~clr.late);
            status.cut  <= evt.cut  | (status.cut  & ~clr.cut);
        end
    end

    always_comb begin
        word = pack_word(cfg, status);
        svc  = (status.late & cfg.late_se) | (status.cut & cfg.cut_se);
    end

    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (word[LATE_ST_BIT] && !(wr && !wdata[LATE_ST_BIT])) |=> word[LATE_ST_BIT]); // R6
    AST_CUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (word[CUT_ST_BIT] && !(wr && !wdata[CUT_ST_BIT])) |=> word[CUT_ST_BIT]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt.late |=> word[LATE_ST_BIT]); // R6
    AST_CUT_LANDS: assert property (@(posedge clk) disable iff (rst)
        evt.cut |=> word[CUT_ST_BIT]); // R4

endmodule

// File: rtl/cell_timeout_monitor.sv
module cell_timeout_monitor
    import ctm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CUT_W     = 11,
    parameter int ADDR_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] cell_arrival,
    input  logic                 tick_125us,
    input  logic [NUM_PORTS-1:0] udt_mode,
    input  logic                 check_late,
    input  logic [CUT_W-1:0]     cut_period,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_PORTS-1:0] timeout_vec,
    output logic                 rx_timeout_srv,
    output logic [NUM_PORTS-1:0] dummy_req
);

    localparam int CNT_W = int'(max2(PERIOD_W, CUT_W));

    logic [WORD_W-1:0]    words [NUM_PORTS];
    logic [NUM_PORTS-1:0] late_fire;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        flag_pair_t evt;
        port_cfg_t  cfg;
        logic       wr_sel;

        assign wr_sel       = reg_we && (reg_addr == ADDR_W'(p));
        assign late_fire[p] = evt.late;

        ctm_port_timer #(
            .CNT_W (CNT_W),
            .CUT_W (CUT_W)
        ) u_timer (
            .clk         (clk),
            .rst         (rst),
            .arrival     (cell_arrival[p]),
            .tick        (tick_125us),
            .udt_mode    (udt_mode[p]),
            .late_period (cfg.late_period),
            .cut_period  (cut_period),
            .evt         (evt)
        );

        ctm_port_csr u_csr (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_sel),
            .wdata (reg_wdata),
            .evt   (evt),
            .cfg   (cfg),
            .word  (words[p]),
            .svc   (timeout_vec[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            dummy_req <= '0;
        else
            dummy_req <= late_fire & {NUM_PORTS{check_late}};
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (reg_addr == ADDR_W'(p))
                reg_rdata = words[p];
    end

    assign rx_timeout_srv = |timeout_vec;

    AST_DUMMY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        |dummy_req |=> ((dummy_req & $past(dummy_req)) == '0)); // R5
    AST_DUMMY_GATED: assert property (@(posedge clk) disable iff (rst)
        |dummy_req |-> $past(check_late)); // R5

endmodule

// File: tb/cell_timeout_monitor_test.sv
`timescale 1ns/1ps
module cell_timeout_monitor_test;

    localparam int N   = 4;
    localparam int CW  = 11;
    localparam int AW  = 2;
    localparam int MAXC = 2047;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  cell_arrival = '0;
    logic          tick_125us = 1'b0;
    logic [N-1:0]  udt_mode = '0;
    logic          check_late = 1'b0;
    logic [CW-1:0] cut_period = '1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [N-1:0]  timeout_vec;
    logic          rx_timeout_srv;
    logic [N-1:0]  dummy_req;

    int tests = 0;
    int fails = 0;
    int seen_dummy [N];

    int m_cnt [N];
    bit m_la [N], m_ca [N], m_ls [N], m_cs [N], m_lse [N], m_cse [N];
    int m_per [N];
    int m_dum [N];

    always #2 clk = ~clk;

    cell_timeout_monitor #(.NUM_PORTS(N), .CUT_W(CW)) uut (
        .clk(clk), .rst(rst), .cell_arrival(cell_arrival), .tick_125us(tick_125us),
        .udt_mode(udt_mode), .check_late(check_late), .cut_period(cut_period),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .timeout_vec(timeout_vec),
        .rx_timeout_srv(rx_timeout_srv), .dummy_req(dummy_req)
    );

    always @(negedge clk)
        if (!rst)
            for (int p = 0; p < N; p++) seen_dummy[p] += int'(dummy_req[p]);

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sync();
        @(posedge clk); #1;
    endtask

    function automatic int exp_word(int p);
        return (int'(m_cs[p]) << 14) | (int'(m_cse[p]) << 13) | (int'(m_ls[p]) << 12) |
               (int'(m_lse[p]) << 11) | m_per[p];
    endfunction

    function automatic int exp_vec();
        int v = 0;
        for (int p = 0; p < N; p++)
            if ((m_ls[p] && m_lse[p]) || (m_cs[p] && m_cse[p])) v |= (1 << p);
        return v;
    endfunction

    function automatic void model_time(logic [N-1:0] arr, bit tk);
        for (int p = 0; p < N; p++) begin
            if (arr[p]) begin
                m_cnt[p] = 0; m_la[p] = 1; m_ca[p] = 1;
            end else if (tk && m_cnt[p] < MAXC) begin
                m_cnt[p]++;
            end
        end
    endfunction

    function automatic void model_eval();
        for (int p = 0; p < N; p++) begin
            if (m_la[p] && udt_mode[p] && m_cnt[p] >= m_per[p]) begin
                m_ls[p] = 1; m_la[p] = 0;
                if (check_late) m_dum[p]++;
            end
            if (m_ca[p] && m_cnt[p] >= int'(cut_period)) begin
                m_cs[p] = 1; m_ca[p] = 0;
            end
        end
    endfunction

    function automatic void model_write(int p, logic [15:0] d);
        m_per[p] = int'(d[10:0]); m_lse[p] = d[11]; m_cse[p] = d[13];
        if (!d[12]) m_ls[p] = 0;
        if (!d[14]) m_cs[p] = 0;
    endfunction

    task automatic check_all();
        for (int p = 0; p < N; p++) begin
            reg_addr = AW'(p); #0.5;
            chk("R3 late status", int'(reg_rdata[12]), int'(m_ls[p]));
            chk("R4 cut status", int'(reg_rdata[14]), int'(m_cs[p]));
            chk("R8 word", int'(reg_rdata), exp_word(p));
            chk("R5 dummy count", seen_dummy[p], m_dum[p]);
        end
        chk("R7 summary vector", int'(timeout_vec), exp_vec());
        chk("R7 service flag", int'(rx_timeout_srv), int'(exp_vec() != 0));
        sync();
    endtask

    task automatic drive(logic [N-1:0] arr, bit tk, bit we, int p, logic [15:0] d);
        cell_arrival = arr; tick_125us = tk; reg_we = we;
        reg_addr = AW'(p); reg_wdata = d;
        sync();
        cell_arrival = '0; tick_125us = 1'b0; reg_we = 1'b0;
    endtask

    task automatic do_step(logic [N-1:0] arr, bit tk);
        drive(arr, tk, 1'b0, 0, 16'h0);
        repeat (3) sync();
        model_time(arr, tk);
        model_eval();
        check_all();
    endtask

    task automatic do_write(int p, logic [15:0] d);
        drive('0, 1'b0, 1'b1, p, d);
        repeat (3) sync();
        model_write(p, d);
        model_eval();
        check_all();
    endtask

    task automatic do_mode(logic [N-1:0] u, bit c, logic [CW-1:0] cp);
        udt_mode = u; check_late = c; cut_period = cp;
        repeat (4) sync();
        model_eval();
        check_all();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5EED_0042);
        for (int p = 0; p < N; p++) begin
            seen_dummy[p] = 0; m_cnt[p] = 0; m_la[p] = 1; m_ca[p] = 1;
            m_ls[p] = 0; m_cs[p] = 0; m_lse[p] = 0; m_cse[p] = 0;
            m_per[p] = MAXC; m_dum[p] = 0;
        end
        repeat (3) sync();
        rst = 1'b0;
        sync();

        // R1: reset state
        for (int p = 0; p < N; p++) begin
            reg_addr = AW'(p); #0.5;
            chk("R1 reset word", int'(reg_rdata), 'h07FF);
        end
        chk("R1 reset vector", int'(timeout_vec), 0);
        chk("R1 reset flag", int'(rx_timeout_srv), 0);
        chk("R1 reset dummy", int'(dummy_req), 0);
        sync();

        // R3/R4/R5/R7: directed thresholds, port 1 not in UDT mode
        do_mode(4'b1101, 1'b1, CW'(6));
        for (int p = 0; p < N; p++) do_write(p, 16'(16'h2800 | (p + 2)));
        do_step('1, 1'b0);
        for (int i = 0; i < 8; i++) do_step('0, 1'b1);

        // R6: writing 1 keeps status, writing 0 clears
        do_write(0, 16'h7803);
        do_write(0, 16'h2803);
        do_write(0, 16'h0003);

        // R2: arrival and tick together, arrival wins
        do_step(4'b0001, 1'b1);
        do_step('0, 1'b1);
        do_step('0, 1'b1);
        do_step('0, 1'b1);

        // R6: hardware set and software clear in the same cycle
        do_write(2, 16'h0003);
        do_step(4'b0100, 1'b0);
        do_step('0, 1'b1);
        do_step('0, 1'b1);
        drive('0, 1'b1, 1'b0, 0, 16'h0);
        model_time('0, 1'b1);
        drive('0, 1'b0, 1'b1, 2, 16'h0003);
        model_write(2, 16'h0003);
        model_eval();
        repeat (3) sync();
        reg_addr = 2'd2; #0.5;
        chk("R6 set wins", int'(reg_rdata[12]), 1);
        sync();
        check_all();

        // R2: long silence saturates, late fires once and never again
        do_mode(4'b1111, 1'b1, CW'(MAXC));
        for (int p = 0; p < N; p++) do_write(p, 16'h0FFF);
        do_step('1, 1'b0);
        for (int i = 0; i < 2100; i++) drive('0, 1'b1, 1'b0, 0, 16'h0);
        model_time('0, 1'b0);
        for (int p = 0; p < N; p++) m_cnt[p] = MAXC;
        repeat (3) sync();
        model_eval();
        check_all();
        chk("R2 single fire after saturation", seen_dummy[0] - m_dum[0] + 1, 1);
        do_write(0, 16'h0FFF);
        for (int i = 0; i < 4; i++) do_step('0, 1'b1);

        // Constrained random phase
        do_mode(4'b1011, 1'b1, CW'(9));
        for (int p = 0; p < N; p++) do_write(p, 16'(16'h2800 | (p + 3)));
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 99));
            if (op < 55) begin
                logic [N-1:0] a;
                a = '0;
                for (int p = 0; p < N; p++) a[p] = ($urandom_range(0, 9) == 0);
                do_step(a, 1'b1);
            end else if (op < 75) begin
                logic [15:0] d;
                d = 16'($urandom_range(0, 65535));
                d[10:0] = 11'($urandom_range(0, 12));
                d[15] = 1'b0;
                do_write(int'($urandom_range(0, N - 1)), d);
            end else if (op < 85) begin
                do_mode(N'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                        CW'($urandom_range(0, 20)));
            end else begin
                do_step(N'($urandom_range(0, 15)), 1'b0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule